// File: doc/BRIEF.md
# Address-Keyed 48-Bit Fill Pattern Generator

This block produces the byte stream used to fill a memory region with known pseudo-random data, or to check such a region afterwards. It is built on a 48-bit linear congruential generator. One output word takes two generator updates. The low 31 bits of the word come from the state after the first update, and the top bit comes from the state after the second. Each pattern byte is the low byte of one output word.

In address-keyed mode, the block is loaded with a 32-bit job seed and a starting byte address. On the first byte after a load, and on every byte whose address sits on a 4 KiB boundary, the generator is reseeded. The new seed is derived from the job seed and both halves of the byte's 64-bit address. In plain mode, the generator is seeded once from the job seed and then runs freely. Neighbouring logic can use the full 32-bit word from either mode for decisions such as access order.

The control interface is a load strobe and a one-request-at-a-time step handshake. A step is accepted only while the block is idle. A ready flag rises when the word is available and stays up until the next accepted step or load. A load in the same cycle as a step takes priority, and a load also cancels any word being computed.

Top module: `r48_fill_gen`

## Requirements
- R1: Each generator update replaces the 48-bit state S with (S × 0x5DEECE66D + 0xB) mod 2^48.
- R2: `word_o[30:0]` equals bits [47:17] of the state after the first update. `word_o[31]` equals bit 31 of the state after the second update. `byte_o` equals `word_o[7:0]`.
- R3: Seeding a 32-bit value V sets the state to {V, 16'h330E}. A load with `addr_mode_i`=0 seeds with `job_seed_i` directly.
- R4: With `addr_mode_i`=1 at load, a step reseeds before updating when the byte is the first after the load or when the byte address bits [11:0] are all zero. The seed value is job_seed ^ addr[63:32] ^ addr[31:0]. Any other step continues from the state left by the previous word.
- R5: The first byte after a load has address `start_addr_i`. Each completed word advances the address by one. `byte_addr_o` reports the address of the byte now presented.
- R6: With `addr_mode_i`=0 at load, no reseeding happens at any address, including 4 KiB boundaries.
- R7: `rdy_o` is high only while a finished word is presented. `busy_o` is high from an accepted step until that word finishes. The two are never high together. The word and `rdy_o` hold steady while no step or load arrives.
- R8: A step request made while `busy_o` is high is ignored. It neither starts another word nor alters the one in progress.
- R9: A load takes priority over a step in the same cycle and cancels a word in progress. In the following cycle `busy_o` and `rdy_o` are both low.
- R10: After reset, `rdy_o`, `busy_o`, `word_o`, `byte_o` and `byte_addr_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Load job seed, mode and start address |
| addr_mode_i | input | 1 | 1 = address-keyed reseeding, 0 = plain sequence |
| job_seed_i | input | 32 | Job seed |
| start_addr_i | input | 64 | Address of the first byte |
| step_i | input | 1 | Request the next word (accepted only when idle) |
| busy_o | output | 1 | Word being computed |
| rdy_o | output | 1 | Finished word available |
| word_o | output | 32 | Raw generator output word |
| byte_o | output | 8 | Pattern byte (low byte of the word) |
| byte_addr_o | output | 64 | Address of the presented byte |

## Verification
The main function is tried with several address patterns. A start of zero shows the first-byte reseed. A start a few bytes below 0x1000 shows that the reseed on crossing a boundary differs from free running. A start with nonzero upper address bits shows that the upper half is mixed into the seed. A start just below a 4 GiB boundary shows the carry into the upper half. The same patterns in plain mode, including a start that crosses 0x1000, separate plain running from reseeding. Directed cases cover a step arriving while busy, a load coinciding with a step, and a load cancelling a word in progress; each of these is visible in the word that follows.

// File: rtl/r48_fill_pkg.sv
package r48_fill_pkg;

    localparam int STATE_W   = 48;
    localparam int WORD_W    = 32;
    localparam int SEED_W    = 32;
    localparam int ADDR_W    = 64;
    localparam int PAGE_BITS = 12;
    localparam int LOW_W     = WORD_W - 1;
    localparam int TAP_LO    = STATE_W - LOW_W;

    localparam logic [STATE_W-1:0] LCG_MULT  = 48'h0005_DEEC_E66D;
    localparam logic [STATE_W-1:0] LCG_INC   = 48'h0000_0000_000B;
    localparam logic [15:0]        SEED_TAIL = 16'h330E;

    // split point of the multiplier for the two-stage product
    localparam int MSPLIT = 18;
    localparam int HI_W   = STATE_W - MSPLIT;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FIRST,
        PH_SECOND
    } phase_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [ADDR_W-1:0] addr;
    } fill_res_t;

    function automatic logic [STATE_W-1:0] lcg_advance(input logic [STATE_W-1:0] s);
        return s * LCG_MULT + LCG_INC;
    endfunction

    function automatic logic [SEED_W-1:0] addr_key(input logic [SEED_W-1:0] job,
                                                   input logic [ADDR_W-1:0] a);
        return job ^ a[ADDR_W-1:SEED_W] ^ a[SEED_W-1:0];
    endfunction

    function automatic logic [STATE_W-1:0] seed_expand(input logic [SEED_W-1:0] v);
        return {v, SEED_TAIL};
    endfunction

endpackage

// File: rtl/r48_lcg_unit.sv
module r48_lcg_unit
    import r48_fill_pkg::*;
#(
    parameter bit PIPE_MUL = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush_i,
    input  logic               go_i,
    input  logic [STATE_W-1:0] seed_i,
    output logic               done_o,
    output logic [STATE_W-1:0] state_o
);

    generate
        if (PIPE_MUL) begin : g_two
            logic [STATE_W-1:0] lo_q;
            logic [HI_W-1:0]    hi_q;
            logic [STATE_W-1:0] res_q;
            logic               v0_q;
            logic               v1_q;

            always_ff @(posedge clk) begin
                if (rst || flush_i) begin
                    v0_q <= 1'b0;
                    v1_q <= 1'b0;
                end else begin
                    v0_q <= go_i;
                    v1_q <= v0_q;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    lo_q  <= '0;
                    hi_q  <= '0;
                    res_q <= '0;
                end else begin
                    if (go_i) begin
                        lo_q <= seed_i * {{(STATE_W-MSPLIT){1'b0}}, LCG_MULT[MSPLIT-1:0]};
                        hi_q <= seed_i[HI_W-1:0] *
                                {{(HI_W-17){1'b0}}, LCG_MULT[MSPLIT+16:MSPLIT]};
                    end
                    if (v0_q) begin
                        res_q <= lo_q + {hi_q, {MSPLIT{1'b0}}} + LCG_INC;
                    end
                end
            end

            assign done_o  = v1_q;
            assign state_o = res_q;

            AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
                !(v0_q && v1_q)); // R8

            AST_DONE_FOLLOWS_GO: assert property (@(posedge clk) disable iff (rst)
                (go_i && !flush_i) |=> !done_o); // R1
        end else begin : g_one
            logic [STATE_W-1:0] res_q;
            logic               v_q;

            always_ff @(posedge clk) begin
                if (rst || flush_i) v_q <= 1'b0;
                else                v_q <= go_i;
            end

            always_ff @(posedge clk) begin
                if (rst)       res_q <= '0;
                else if (go_i) res_q <= lcg_advance(seed_i);
            end

            assign done_o  = v_q;
            assign state_o = res_q;

            AST_DONE_FOLLOWS_GO: assert property (@(posedge clk) disable iff (rst)
                (go_i && !flush_i) |=> done_o); // R1
        end
    endgenerate

endmodule

// File: rtl/r48_addr_track.sv
module r48_addr_track #(
    parameter int AW = 64,
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic [AW-1:0] addr_i,
    input  logic          adv_i,
    output logic [AW-1:0] cur_o,
    output logic          first_o,
    output logic          page_start_o
);

    logic [AW-1:0] cur_q;
    logic          first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            first_q <= 1'b1;
        end else if (load_i) begin
            cur_q   <= addr_i;
            first_q <= 1'b1;
        end else if (adv_i) begin
            cur_q   <= cur_q + AW'(1);
            first_q <= 1'b0;
        end
    end

    assign cur_o        = cur_q;
    assign first_o      = first_q;
    assign page_start_o = (cur_q[PW-1:0] == '0);

    AST_ADDR_INC: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !load_i) |=> (cur_o == $past(cur_o) + AW'(1))); // R5

    AST_FIRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (adv_i && !load_i) |=> !first_o); // R4

    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (first_o && cur_o == $past(addr_i))); // R5

endmodule

// File: rtl/r48_fill_gen.sv
module r48_fill_gen
    import r48_fill_pkg::*;
#(
    parameter bit PIPE_MUL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic              addr_mode_i,
    input  logic [SEED_W-1:0] job_seed_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic              step_i,
    output logic              busy_o,
    output logic              rdy_o,
    output logic [WORD_W-1:0] word_o,
    output logic [7:0]        byte_o,
    output logic [ADDR_W-1:0] byte_addr_o
);

    phase_e             phase_q;
    fill_res_t          res_q;
    logic               rdy_q;
    logic [STATE_W-1:0] state_q;
    logic [SEED_W-1:0]  job_q;
    logic               mode_q;
    logic [LOW_W-1:0]   lo_q;

    logic [ADDR_W-1:0]  cur_addr;
    logic               first_byte;
    logic               page_start;

    logic               accept;
    logic               reseed;
    logic [STATE_W-1:0] base_state;
    logic               lcg_go;
    logic [STATE_W-1:0] lcg_seed;
    logic               lcg_done;
    logic [STATE_W-1:0] lcg_state;
    logic               finish;

    r48_addr_track #(
        .AW (ADDR_W),
        .PW (PAGE_BITS)
    ) u_addr (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load_i),
        .addr_i       (start_addr_i),
        .adv_i        (finish),
        .cur_o        (cur_addr),
        .first_o      (first_byte),
        .page_start_o (page_start)
    );

    always_comb begin
        accept     = (phase_q == PH_IDLE) && step_i && !load_i;
        reseed     = mode_q && (first_byte || page_start);
        base_state = reseed ? seed_expand(addr_key(job_q, cur_addr)) : state_q;
        lcg_go     = accept || ((phase_q == PH_FIRST) && lcg_done && !load_i);
        lcg_seed   = (phase_q == PH_IDLE) ? base_state : lcg_state;
        finish     = (phase_q == PH_SECOND) && lcg_done && !load_i;
    end

    r48_lcg_unit #(
        .PIPE_MUL (PIPE_MUL)
    ) u_lcg (
        .clk     (clk),
        .rst     (rst),
        .flush_i (load_i),
        .go_i    (lcg_go),
        .seed_i  (lcg_seed),
        .done_o  (lcg_done),
        .state_o (lcg_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            rdy_q   <= 1'b0;
            res_q   <= '0;
            state_q <= '0;
            job_q   <= '0;
            mode_q  <= 1'b0;
            lo_q    <= '0;
        end else if (load_i) begin
            phase_q <= PH_IDLE;
            rdy_q   <= 1'b0;
            job_q   <= job_seed_i;
            mode_q  <= addr_mode_i;
            state_q <= seed_expand(job_seed_i);
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (step_i) begin
                        phase_q <= PH_FIRST;
                        rdy_q   <= 1'b0;
                    end
                end
                PH_FIRST: begin
                    if (lcg_done) begin
                        lo_q    <= lcg_state[STATE_W-1:TAP_LO];
                        phase_q <= PH_SECOND;
                    end
                end
                PH_SECOND: begin
                    if (lcg_done) begin
                        res_q.word <= {lcg_state[WORD_W-1], lo_q};
                        res_q.addr <= cur_addr;
                        state_q    <= lcg_state;
                        rdy_q      <= 1'b1;
                        phase_q    <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy_o      = (phase_q != PH_IDLE);
    assign rdy_o       = rdy_q;
    assign word_o      = res_q.word;
    assign byte_o      = res_q.word[7:0];
    assign byte_addr_o = res_q.addr;

    AST_RDY_BUSY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rdy_o && busy_o)); // R7

    AST_BUSY_RESOLVES: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !load_i) |=> (busy_o || rdy_o)); // R7

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rdy_o && !step_i && !load_i) |=> (rdy_o && $stable(word_o) && $stable(byte_addr_o))); // R7

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (!busy_o && !rdy_o)); // R9

    AST_DONE_ONLY_RUNNING: assert property (@(posedge clk) disable iff (rst)
        lcg_done |-> (phase_q != PH_IDLE)); // R9

    AST_BUSY_STEP_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SECOND && !lcg_done && step_i && !load_i) |=> (phase_q == PH_SECOND)); // R8

endmodule

// File: tb/sim_r48_fill_gen.sv
`timescale 1ns/1ps
module sim_r48_fill_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic        addr_mode_i = 1'b0;
    logic [31:0] job_seed_i = '0;
    logic [63:0] start_addr_i = '0;
    logic        step_i = 1'b0;
    logic        busy_o;
    logic        rdy_o;
    logic [31:0] word_o;
    logic [7:0]  byte_o;
    logic [63:0] byte_addr_o;

    always #2.5 clk = ~clk;

    r48_fill_gen u0 (
        .clk          (clk),
        .rst          (rst),
        .load_i       (load_i),
        .addr_mode_i  (addr_mode_i),
        .job_seed_i   (job_seed_i),
        .start_addr_i (start_addr_i),
        .step_i       (step_i),
        .busy_o       (busy_o),
        .rdy_o        (rdy_o),
        .word_o       (word_o),
        .byte_o       (byte_o),
        .byte_addr_o  (byte_addr_o)
    );

    typedef struct packed {
        logic        mode;
        logic [31:0] seed;
        logic [63:0] addr;
        logic [7:0]  n;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 32'h0000_0000, 64'h0000_0000_0000_0000, 8'd6},
        '{1'b1, 32'h1234_5678, 64'h0000_0000_0000_0FFC, 8'd8},
        '{1'b1, 32'hCAFE_F00D, 64'hDEAD_BEEF_0000_1FFE, 8'd5},
        '{1'b1, 32'hFFFF_FFFF, 64'h0000_0001_FFFF_FFFE, 8'd5},
        '{1'b0, 32'h0000_0000, 64'h0000_0000_0000_0FFE, 8'd5},
        '{1'b0, 32'hFFFF_FFFF, 64'h0000_0000_0000_0000, 8'd4},
        '{1'b0, 32'h0BAD_CAFE, 64'h0000_0000_0000_0FFF, 8'd4}
    };

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    // independent model state
    logic [47:0] m_state;
    logic [31:0] m_job;
    logic [63:0] m_addr;
    logic        m_first;
    logic        m_mode;

    function automatic logic [47:0] m_upd(input logic [47:0] s);
        return s * 48'h0005_DEEC_E66D + 48'hB;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic m_load(input logic mode, input logic [31:0] seed, input logic [63:0] a);
        m_mode  = mode;
        m_job   = seed;
        m_addr  = a;
        m_first = 1'b1;
        m_state = {seed, 16'h330E};
    endtask

    task automatic m_next(output logic [31:0] w, output logic [63:0] a);
        logic [30:0] t;
        if (m_mode && (m_first || m_addr[11:0] == 12'h000))
            m_state = {m_job ^ m_addr[63:32] ^ m_addr[31:0], 16'h330E};
        m_state = m_upd(m_state);
        t       = m_state[47:17];
        m_state = m_upd(m_state);
        w       = {m_state[31], t};
        a       = m_addr;
        m_addr  = m_addr + 64'd1;
        m_first = 1'b0;
    endtask

    task automatic do_load(input logic mode, input logic [31:0] seed, input logic [63:0] a);
        @(negedge clk);
        load_i       = 1'b1;
        addr_mode_i  = mode;
        job_seed_i   = seed;
        start_addr_i = a;
        @(negedge clk);
        load_i = 1'b0;
        m_load(mode, seed, a);
    endtask

    task automatic wait_rdy();
        int k = 0;
        while (!rdy_o && k < 40) begin
            @(negedge clk);
            k++;
        end
        if (!rdy_o) chk(1'b0, "R7", "ready timeout", 64'(rdy_o), 64'd1);
    endtask

    task automatic pulse_step();
        @(negedge clk);
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
    endtask

    task automatic check_word(input string req);
        logic [31:0] ew;
        logic [63:0] ea;
        wait_rdy();
        m_next(ew, ea);
        chk(word_o == ew, req, "word (R1 R2)", 64'(word_o), 64'(ew));
        chk(byte_o == ew[7:0], "R2", "byte", 64'(byte_o), 64'(ew[7:0]));
        chk(byte_addr_o == ea, "R5", "byte address", byte_addr_o, ea);
    endtask

    task automatic step_check(input string req);
        pulse_step();
        check_word(req);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            chk(1'b0, "R7", "watchdog expired", 64'(cyc), 64'd100000);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        chk(rdy_o == 1'b0, "R10", "rdy after reset", 64'(rdy_o), 64'd0);
        chk(busy_o == 1'b0, "R10", "busy after reset", 64'(busy_o), 64'd0);
        chk(word_o == 32'd0, "R10", "word after reset", 64'(word_o), 64'd0);
        chk(byte_o == 8'd0, "R10", "byte after reset", 64'(byte_o), 64'd0);
        chk(byte_addr_o == 64'd0, "R10", "addr after reset", byte_addr_o, 64'd0);

        // table walk: address-keyed (R4) and plain (R3, R6) sequences
        for (int v = 0; v < NVEC; v++) begin
            do_load(VECS[v].mode, VECS[v].seed, VECS[v].addr);
            for (int j = 0; j < int'(VECS[v].n); j++)
                step_check(VECS[v].mode ? "R4" : "R6");
        end

        // R7 result holds while idle, busy exclusive with ready
        do_load(1'b1, 32'hA5A5_5A5A, 64'h0000_0000_0000_3000);
        pulse_step();
        chk(busy_o == 1'b1, "R7", "busy after accept", 64'(busy_o), 64'd1);
        chk(rdy_o == 1'b0, "R7", "rdy after accept", 64'(rdy_o), 64'd0);
        check_word("R4");
        held = word_o;
        repeat (5) @(negedge clk);
        chk(rdy_o == 1'b1, "R7", "rdy held", 64'(rdy_o), 64'd1);
        chk(word_o == held, "R7", "word held", 64'(word_o), 64'(held));

        // R8 step while busy is ignored
        pulse_step();
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        check_word("R8");
        repeat (3) @(negedge clk);
        chk(busy_o == 1'b0, "R8", "no extra word started", 64'(busy_o), 64'd0);
        chk(rdy_o == 1'b1, "R8", "ready kept", 64'(rdy_o), 64'd1);
        step_check("R8");

        // R9 load and step in the same cycle: load wins
        @(negedge clk);
        load_i       = 1'b1;
        step_i       = 1'b1;
        addr_mode_i  = 1'b1;
        job_seed_i   = 32'h0F0F_1234;
        start_addr_i = 64'h0000_0000_0000_7FF0;
        @(negedge clk);
        load_i = 1'b0;
        step_i = 1'b0;
        m_load(1'b1, 32'h0F0F_1234, 64'h0000_0000_0000_7FF0);
        chk(busy_o == 1'b0, "R9", "busy after load+step", 64'(busy_o), 64'd0);
        chk(rdy_o == 1'b0, "R9", "rdy after load+step", 64'(rdy_o), 64'd0);
        step_check("R9");

        // R9 load cancels a word in progress
        pulse_step();
        chk(busy_o == 1'b1, "R9", "busy before abort", 64'(busy_o), 64'd1);
        do_load(1'b0, 32'h7777_0001, 64'h0000_0000_0000_0010);
        chk(busy_o == 1'b0, "R9", "busy after abort", 64'(busy_o), 64'd0);
        chk(rdy_o == 1'b0, "R9", "rdy after abort", 64'(rdy_o), 64'd0);
        repeat (6) @(negedge clk);
        chk(rdy_o == 1'b0, "R9", "no late result", 64'(rdy_o), 64'd0);
        step_check("R3");
        step_check("R3");

        summary();
        $finish;
    end

endmodule